// File: doc/BRIEF.md
# Host Bus Word Swap Adapter

This block connects a host bus, strapped after reset for either 16-bit or 32-bit operation, to an internal bank of 32-bit registers and data FIFO ports. In 32-bit operation it passes whole words straight through. In 16-bit operation it places each half-word access on one half of the internal word. It also drives a separate write enable for each half, so that a 16-bit write changes only the half it targets.

Which half an access reaches depends on host address bit 1 and on a 32-bit swap control register that lives inside the block at byte offset 98h. Only the exact value FFFFFFFFh in that register reverses the mapping. Any other value, including values that are almost all ones, keeps the normal mapping. The host reads and writes the swap register through the same bus, and those accesses are never forwarded to the internal bank.

Interpretation of the swap value is held in a registered flag. A write to the swap register therefore steers only the accesses that follow it, and never the access that carries the write. Data leaving the transmit FIFO and entering the receive FIFO is always ordered low half first. That ordering is fixed by the internal word layout and is not affected by this block.

Top module: `hbus_word_steer`

## Requirements
- R1: After a synchronous active-low reset the swap register reads 00000000h, and 16-bit accesses use the normal mapping.
- R2: In 32-bit mode a write to the internal bank asserts both half write enables. It drives the host word unchanged onto the internal write data and drives the word address with bits 1:0 at zero, whatever the swap register holds and whatever the value of address bit 1.
- R3: In 32-bit mode a read returns the full internal word on host read data, with bits 31:16 carrying the high half, whatever the swap register holds.
- R4: In 16-bit mode, with the swap register not equal to FFFFFFFFh, address bit 1 = 1 asserts only the high-half write enable and address bit 1 = 0 asserts only the low-half enable. The host bits 15:0 are copied onto both halves of the internal write data.
- R5: In 16-bit mode, with the swap register equal to FFFFFFFFh, the mapping is reversed: address bit 1 = 1 selects the low half and address bit 1 = 0 selects the high half, for both writes and reads.
- R6: Swap register values that differ from FFFFFFFFh in any bit (for example 0000FFFFh or FFFEFFFFh) keep the normal mapping.
- R7: In 16-bit mode a read returns the selected half on host read data bits 15:0, with bits 31:16 at zero.
- R8: Accesses whose word address matches byte offset 98h read or write the swap register and assert neither the internal write nor the internal read strobe. A 16-bit write there changes only the selected half of the swap register.
- R9: A write to the swap register takes effect from the next access: the write itself is steered by the value held before it.
- R10: When the host issues no read or write, neither the internal write strobe nor the internal read strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus16 | input | 1 | 1 = 16-bit host bus, 0 = 32-bit; static after reset |
| host_addr | input | ADDR_W-1 (7) | Host half-word address, byte address bits ADDR_W-1:1 |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W (32) | Host write data; only bits 15:0 used in 16-bit mode |
| host_rdata | output | DATA_W (32) | Host read data |
| reg_addr | output | ADDR_W (8) | Internal word-aligned byte address |
| reg_wr | output | 1 | Internal write strobe |
| reg_rd | output | 1 | Internal read strobe |
| reg_be_hi | output | 1 | Write enable for internal bits 31:16 |
| reg_be_lo | output | 1 | Write enable for internal bits 15:0 |
| reg_wdata | output | DATA_W (32) | Internal write data |
| reg_rdata | input | DATA_W (32) | Internal read data, valid in the cycle of reg_rd |

## Verification
The hardest situation to reach is the cycle in which the swap register changes. The write that completes the all-ones pattern must still be steered by the old mapping. The write that breaks that pattern from the swapped state must be steered by the swapped mapping. The bench assembles the register from two 16-bit halves and then overwrites one half while swapped. It reads both halves back and checks where the new data landed. Partial patterns such as 0000FFFFh and FFFEFFFFh are built the same way, to show that they leave the normal mapping in place.

// File: rtl/hws_pkg.sv
// Package: shared lane type and lane choice for the word swap adapter.
// Assumes a host word of two half-word lanes.
package hws_pkg;
    localparam int HALVES = 2;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Lane targeted by a 16-bit access: address bit 1 reversed when swap is on.
    function automatic lane_e pick_lane(input logic a1, input logic swapped);
        return lane_e'(a1 ^ swapped);
    endfunction
endpackage

// File: rtl/hws_swap_reg.sv
// Swap control register: decodes its own word address and holds the 32-bit
// value. Keeps a registered flag that is set only for the exact all-ones value.
// Assumes bus width mode is static after reset; the flag and the value are
// loaded in the same edge, so the new value steers only later accesses.
module hws_swap_reg
    import hws_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SWAP_OFS = 'h98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus16,
    input  logic [ADDR_W-1:2] word_addr,
    input  logic              host_wr,
    input  lane_e             lane,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              swap_hit,
    output logic [DATA_W-1:0] swap_q,
    output logic              swap_act
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] OFS_B = ADDR_W'(SWAP_OFS);

    logic [DATA_W-1:0] swap_d;
    logic              load;

    // Address decode of the swap register word.
    always_comb begin
        swap_hit = (word_addr == OFS_B[ADDR_W-1:2]);
        load     = swap_hit && host_wr;
    end

    // Next value: whole word in 32-bit mode, one half otherwise.
    always_comb begin
        swap_d = swap_q;
        if (!bus16) begin
            swap_d = host_wdata;
        end else if (lane == LANE_HI) begin
            swap_d[DATA_W-1:HALF_W] = host_wdata[HALF_W-1:0];
        end else begin
            swap_d[HALF_W-1:0] = host_wdata[HALF_W-1:0];
        end
    end

    // Storage of the swap value and its registered all-ones flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_q   <= '0;
            swap_act <= 1'b0;
        end else if (load) begin
            swap_q   <= swap_d;
            swap_act <= (swap_d == {DATA_W{1'b1}});
        end
    end
endmodule

// File: rtl/hws_lane_steer.sv
// Lane steering: picks the target half of the internal word and forms the
// internal address, strobes, per-half write enables and write data.
// Assumes accesses that hit the swap register stay inside the adapter.
module hws_lane_steer
    import hws_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              bus16,
    input  logic [ADDR_W-1:1] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              swap_act,
    input  logic              swap_hit,
    output lane_e             lane,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [HALVES-1:0] reg_be,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int HALF_W = DATA_W / 2;

    // Lane choice and strobes forwarded to the internal bank.
    always_comb begin
        lane     = pick_lane(host_addr[1], swap_act);
        reg_addr = {host_addr[ADDR_W-1:2], 2'b00};
        reg_wr   = host_wr && !swap_hit;
        reg_rd   = host_rd && !swap_hit;
    end

    // One write enable and one data lane per internal half.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_comb begin
            if (!bus16) begin
                reg_be[h] = reg_wr;
                reg_wdata[h*HALF_W +: HALF_W] = host_wdata[h*HALF_W +: HALF_W];
            end else begin
                reg_be[h] = reg_wr && (lane == lane_e'(h));
                reg_wdata[h*HALF_W +: HALF_W] = host_wdata[HALF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/hws_rd_mux.sv
// Read multiplexer: returns either the swap register or the internal word,
// whole in 32-bit mode, as the selected half on the low lane in 16-bit mode.
// Assumes internal read data is valid in the cycle of the read strobe.
module hws_rd_mux
    import hws_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              bus16,
    input  lane_e             lane,
    input  logic              swap_hit,
    input  logic [DATA_W-1:0] swap_q,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] src;

    // Source word: internal swap register or internal bank.
    always_comb begin
        src = swap_hit ? swap_q : reg_rdata;
    end

    // Host lane drive: low lane gets the chosen half, high lane is cleared in 16-bit mode.
    for (genvar h = 0; h < HALVES; h++) begin : g_out
        if (h == 0) begin : g_low
            always_comb begin
                if (bus16) begin
                    host_rdata[HALF_W-1:0] = (lane == LANE_HI) ?
                        src[DATA_W-1:HALF_W] : src[HALF_W-1:0];
                end else begin
                    host_rdata[HALF_W-1:0] = src[HALF_W-1:0];
                end
            end
        end else begin : g_high
            always_comb begin
                host_rdata[h*HALF_W +: HALF_W] =
                    bus16 ? '0 : src[h*HALF_W +: HALF_W];
            end
        end
    end
endmodule

// File: rtl/hbus_word_steer.sv
// Top: host bus word swap adapter. Connects a 16/32-bit host bus to a bank
// of 32-bit internal registers and FIFO ports, with an internal swap register.
// Assumes bus16 is static after reset and that the host issues one access per cycle.
module hbus_word_steer
    import hws_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SWAP_OFS = 'h98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus16,
    input  logic [ADDR_W-1:1] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              reg_be_hi,
    output logic              reg_be_lo,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    lane_e             lane;
    logic              swap_hit;
    logic              swap_act;
    logic [DATA_W-1:0] swap_q;
    logic [HALVES-1:0] reg_be;

    hws_swap_reg #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .SWAP_OFS(SWAP_OFS)
    ) u_swap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus16     (bus16),
        .word_addr (host_addr[ADDR_W-1:2]),
        .host_wr   (host_wr),
        .lane      (lane),
        .host_wdata(host_wdata),
        .swap_hit  (swap_hit),
        .swap_q    (swap_q),
        .swap_act  (swap_act)
    );

    hws_lane_steer #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_steer (
        .bus16     (bus16),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .swap_act  (swap_act),
        .swap_hit  (swap_hit),
        .lane      (lane),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata)
    );

    hws_rd_mux #(
        .DATA_W(DATA_W)
    ) u_rmux (
        .bus16     (bus16),
        .lane      (lane),
        .swap_hit  (swap_hit),
        .swap_q    (swap_q),
        .reg_rdata (reg_rdata),
        .host_rdata(host_rdata)
    );

    // Per-half enables brought out as named ports.
    always_comb begin
        reg_be_lo = reg_be[0];
        reg_be_hi = reg_be[1];
    end
endmodule

// File: rtl/hws_chk.sv
// Checker for the word swap adapter, bound into the top module.
// Assumes it sees the top's ports plus the swap value and its flag.
module hws_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SWAP_OFS = 'h98
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus16,
    input logic [ADDR_W-1:1]   host_addr,
    input logic                host_wr,
    input logic                host_rd,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic                reg_be_hi,
    input logic                reg_be_lo,
    input logic [DATA_W/2-1:0] rdata_hi,
    input logic [DATA_W-1:0]   swap_q,
    input logic                swap_act
);
    localparam logic [ADDR_W-1:0] OFS_B = ADDR_W'(SWAP_OFS);

    logic hit;
    always_comb hit = (host_addr[ADDR_W-1:2] == OFS_B[ADDR_W-1:2]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (swap_q == '0 && !swap_act));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd) |-> (!reg_wr && !reg_rd));

    // R2
    wide_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus16 && reg_wr) |-> (reg_be_hi && reg_be_lo));

    // R4
    narrow_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus16 && reg_wr) |-> $onehot({reg_be_hi, reg_be_lo}));

    // R5
    swapped_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus16 && reg_wr && swap_act) |-> (reg_be_hi == !host_addr[1]));

    // R6
    exact_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_act == (swap_q == {DATA_W{1'b1}}));

    // R7
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus16 |-> (rdata_hi == '0));

    // R8
    swap_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (!reg_wr && !reg_rd));

    // R9
    swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && host_wr) |=> $stable(swap_q));
endmodule

bind hbus_word_steer hws_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SWAP_OFS(SWAP_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus16    (bus16),
    .host_addr(host_addr),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_be_hi(reg_be_hi),
    .reg_be_lo(reg_be_lo),
    .rdata_hi (host_rdata[DATA_W-1:DATA_W/2]),
    .swap_q   (swap_q),
    .swap_act (swap_act)
);

// File: tb/hbus_word_steer_test.sv
// Directed bench for the word swap adapter, with a model register bank.
module hbus_word_steer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus16 = 1'b1;
    logic [7:1]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  reg_addr;
    logic        reg_wr, reg_rd, reg_be_hi, reg_be_lo;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] mem [64];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    hbus_word_steer uut (
        .clk(clk), .rst_n(rst_n), .bus16(bus16),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_be_hi(reg_be_hi), .reg_be_lo(reg_be_lo),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Model internal bank: combinational read, per-half write.
    assign reg_rdata = mem[reg_addr[7:2]];
    always @(posedge clk) begin
        if (reg_wr && reg_be_hi) mem[reg_addr[7:2]][31:16] <= reg_wdata[31:16];
        if (reg_wr && reg_be_lo) mem[reg_addr[7:2]][15:0]  <= reg_wdata[15:0];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Drive one access after the falling edge; outputs settle 1 ns later.
    task automatic drive(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a[7:1];
        host_wr    = wr;
        host_rd    = rd;
        host_wdata = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
    endtask

    task automatic wr_acc(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, 1'b0, a, d);
        @(posedge clk);
        idle();
    endtask

    task automatic rd_acc(input logic [7:0] a, output logic [31:0] q);
        drive(1'b0, 1'b1, a, '0);
        q = host_rdata;
        @(posedge clk);
        idle();
    endtask

    task automatic do_reset(input logic mode16);
        @(negedge clk);
        rst_n = 1'b0;
        bus16 = mode16;
        host_wr = 1'b0;
        host_rd = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] q;
        do_reset(1'b1);
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        rd_acc(8'h98, q); chk("R1 swap low half after reset", q, 32'h0);
        rd_acc(8'h9A, q); chk("R1 swap high half after reset", q, 32'h0);
    endtask

    task automatic t_idle();
        drive(1'b0, 1'b0, 8'h10, 32'h5555_5555);
        chk("R10 idle write strobe", {31'b0, reg_wr}, 32'h0);
        chk("R10 idle read strobe", {31'b0, reg_rd}, 32'h0);
        idle();
    endtask

    task automatic t_narrow_normal();
        logic [31:0] q;
        drive(1'b1, 1'b0, 8'h12, 32'h0000_BEEF);
        chk("R4 A1=1 enables {hi,lo}", {30'b0, reg_be_hi, reg_be_lo}, 32'h2);
        chk("R4 data copied to both halves", reg_wdata, 32'hBEEF_BEEF);
        chk("R4 word address", {24'b0, reg_addr}, 32'h10);
        @(posedge clk); idle();
        drive(1'b1, 1'b0, 8'h10, 32'h0000_CAFE);
        chk("R4 A1=0 enables {hi,lo}", {30'b0, reg_be_hi, reg_be_lo}, 32'h1);
        @(posedge clk); idle();
        rd_acc(8'h10, q); chk("R7 read low half", q, 32'h0000_CAFE);
        rd_acc(8'h12, q); chk("R7 read high half, upper zero", q, 32'h0000_BEEF);
    endtask

    task automatic t_partial_patterns();
        logic [31:0] q;
        drive(1'b1, 1'b0, 8'h98, 32'h0000_FFFF);
        chk("R8 swap write not forwarded", {31'b0, reg_wr}, 32'h0);
        @(posedge clk); idle();
        drive(1'b1, 1'b0, 8'h12, 32'h0000_BEEF);
        chk("R6 0000FFFF keeps normal lane", {30'b0, reg_be_hi, reg_be_lo}, 32'h2);
        @(posedge clk); idle();
        wr_acc(8'h9A, 32'h0000_FFFE);
        rd_acc(8'h12, q); chk("R6 FFFEFFFF keeps normal read", q, 32'h0000_BEEF);
        rd_acc(8'h98, q); chk("R8 swap low half kept", q, 32'h0000_FFFF);
        rd_acc(8'h9A, q); chk("R8 swap high half written", q, 32'h0000_FFFE);
    endtask

    task automatic t_narrow_swapped();
        logic [31:0] q;
        wr_acc(8'h9A, 32'h0000_FFFF);
        drive(1'b1, 1'b0, 8'h12, 32'h0000_1111);
        chk("R5 A1=1 swapped enables {hi,lo}", {30'b0, reg_be_hi, reg_be_lo}, 32'h1);
        @(posedge clk); idle();
        rd_acc(8'h10, q); chk("R5 A1=0 swapped reads high half", q, 32'h0000_BEEF);
        rd_acc(8'h12, q); chk("R5 A1=1 swapped reads low half", q, 32'h0000_1111);
    endtask

    task automatic t_swap_timing();
        logic [31:0] q;
        wr_acc(8'h98, 32'h0000_1234);
        rd_acc(8'h9A, q); chk("R9 write steered by old swapped map", q, 32'h0000_1234);
        rd_acc(8'h98, q); chk("R9 other swap half kept", q, 32'h0000_FFFF);
        rd_acc(8'h12, q); chk("R9 next access uses normal map", q, 32'h0000_BEEF);
    endtask

    task automatic t_wide();
        logic [31:0] q;
        do_reset(1'b0);
        rd_acc(8'h98, q); chk("R1 swap reset in 32-bit mode", q, 32'h0);
        drive(1'b1, 1'b0, 8'h98, 32'hFFFF_FFFF);
        chk("R8 32-bit swap write not forwarded", {31'b0, reg_wr}, 32'h0);
        @(posedge clk); idle();
        rd_acc(8'h98, q); chk("R8 32-bit swap readback", q, 32'hFFFF_FFFF);
        drive(1'b1, 1'b0, 8'h22, 32'hA1B2_C3D4);
        chk("R2 both enables", {30'b0, reg_be_hi, reg_be_lo}, 32'h3);
        chk("R2 data passed", reg_wdata, 32'hA1B2_C3D4);
        chk("R2 aligned address", {24'b0, reg_addr}, 32'h20);
        @(posedge clk); idle();
        rd_acc(8'h22, q); chk("R3 full word despite swap", q, 32'hA1B2_C3D4);
        rd_acc(8'h20, q); chk("R3 full word A1=0", q, 32'hA1B2_C3D4);
    endtask

    initial begin
        t_reset_state();
        t_idle();
        t_narrow_normal();
        t_partial_patterns();
        t_narrow_swapped();
        t_swap_timing();
        t_wide();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end
endmodule